// File: doc/BRIEF.md
# E1 Timeslot-16 Signalling Change Detector

This block collects the channel-associated signalling bytes that arrive in timeslot 16 of an E1 line, one byte per frame across a 16-frame multiframe. It fills a hidden shadow bank while the multiframe is in progress. Once the last frame's byte has been taken, it moves the whole shadow bank into a visible bank of 16 byte registers in a single cycle. A CPU reads the visible bank through a small address/data port. The contents stay unchanged until the next complete multiframe overwrites them, which gives software about 2 ms to read them.

When the visible bank is overwritten, the block compares the new multiframe with the one it replaces. If any byte differs, it sets a sticky change interrupt, which stays high until the CPU pulses a clear strobe. Capture runs only while both the frame-alignment sync and the signalling multiframe sync are held. A multiframe that loses either sync, or that breaks the frame sequence, is thrown away without touching the visible bank or the interrupt. The block does not extract the timeslot from the line; an upstream framer delivers each timeslot-16 byte together with its frame number.

Top module: `casChangeDetect`

## Requirements
- R1: After reset, all 16 visible registers read 0xFF and `changeIrq` is low.
- R2: The byte delivered with frame number n (0 to 15) appears in visible register n once the multiframe has completed.
- R3: During a multiframe in progress, the visible registers keep the previous multiframe's values.
- R4: Take the rising edge that captures the frame-15 byte. `changeIrq` rises on the next rising edge after it, and not on that edge itself.
- R5: A complete multiframe identical to the visible contents leaves `changeIrq` low.
- R6: If `ts0Sync` or `mfSync` is low while a multiframe is in progress, that multiframe is discarded: the visible registers are unchanged and no interrupt is raised, even if its later frames arrive.
- R7: A capture starts only on a frame-0 byte. A byte whose frame number is not the next expected one aborts the multiframe, and bytes arriving outside a multiframe are ignored.
- R8: `changeIrq` stays high until `clrIrq` is pulsed. If a new change and `clrIrq` occur in the same cycle, the interrupt remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ts16Valid | input | 1 | A timeslot-16 byte is present this cycle |
| ts16Byte | input | 8 | Timeslot-16 byte |
| frameNum | input | 4 | Frame number 0 to 15 of the byte |
| ts0Sync | input | 1 | Frame-alignment (timeslot 0) sync held |
| mfSync | input | 1 | Signalling multiframe (timeslot 16) sync held |
| rdAddr | input | 4 | CPU read address of a visible register |
| rdData | output | 8 | Visible register contents at `rdAddr` |
| clrIrq | input | 1 | CPU clear strobe for the change interrupt |
| changeIrq | output | 1 | Sticky signalling-change interrupt |

## Verification
The bench reads a register in the middle of a multiframe. A design that writes bytes straight into the visible bank would return the new value there instead of the old one. It samples `changeIrq` on the edge that takes frame 15. An early interrupt would show before the update had finished. It drops each sync alone partway through, and separately skips a frame number, then lets the remaining frames arrive. A design that keeps capturing from frame 15 would commit a partial multiframe. It also sends an identical multiframe, and holds the clear strobe across a commit cycle. These two cases catch a compare that fires on every commit and a clear that wins over a new change.

// File: rtl/casPkg.sv
package casPkg;
  localparam int SLOTS  = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(SLOTS);

  typedef struct packed {
    logic             capture;
    logic             commit;
    logic [IDX_W-1:0] idx;
  } casStrobe_t;
endpackage

// File: rtl/casCtrl.sv
module casCtrl
  import casPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ts16Valid,
  input  logic [IDX_W-1:0] frameNum,
  input  logic             ts0Sync,
  input  logic             mfSync,
  output casStrobe_t       stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  logic             capturing;
  logic [IDX_W-1:0] nextIdx;
  logic             commitPend;
  logic             syncOk;
  logic             isStart;
  logic             inSeq;

  always_comb begin
    syncOk      = ts0Sync && mfSync;
    isStart     = ts16Valid && syncOk && (frameNum == '0);
    inSeq       = ts16Valid && syncOk && capturing && (frameNum == nextIdx) && (frameNum != '0);
    stb.capture = isStart || inSeq;
    stb.idx     = frameNum;
    stb.commit  = commitPend && syncOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capturing  <= 1'b0;
      nextIdx    <= '0;
      commitPend <= 1'b0;
    end else begin
      commitPend <= inSeq && (frameNum == LAST_IDX);
      if (isStart) begin
        capturing <= 1'b1;
        nextIdx   <= IDX_W'(1);
      end else if (inSeq) begin
        if (frameNum == LAST_IDX) capturing <= 1'b0;
        else                      nextIdx   <= nextIdx + IDX_W'(1);
      end else if (capturing && (!syncOk || ts16Valid)) begin
        capturing <= 1'b0;
      end
    end
  end

  // R4: a commit follows only the capture of the final frame
  assert_commit_after_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> $past(stb.capture && (stb.idx == LAST_IDX)));

  // R6: no commit while either sync is missing
  assert_commit_needs_sync_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ts0Sync || !mfSync) |-> !stb.commit);
endmodule

// File: rtl/casData.sv
module casData
  import casPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  casStrobe_t        stb,
  input  logic [BYTE_W-1:0] ts16Byte,
  input  logic [IDX_W-1:0]  rdAddr,
  input  logic              clrIrq,
  output logic [BYTE_W-1:0] rdData,
  output logic              changeIrq
);
  logic [SLOTS-1:0][BYTE_W-1:0] shadowBank;
  logic [SLOTS-1:0][BYTE_W-1:0] visBank;
  logic                         differs;

  always_comb begin
    differs = (shadowBank != visBank);
    rdData  = visBank[rdAddr];
  end

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowBank[g] <= '1;
        visBank[g]    <= '1;
      end else begin
        if (stb.capture && (stb.idx == IDX_W'(g))) shadowBank[g] <= ts16Byte;
        if (stb.commit) visBank[g] <= shadowBank[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   changeIrq <= 1'b0;
    else if (stb.commit && differs) changeIrq <= 1'b1;
    else if (clrIrq)             changeIrq <= 1'b0;
  end

  // R3: the visible bank moves only on a commit
  assert_vis_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(visBank));

  // R4: the interrupt rises only right after a commit
  assert_irq_after_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(changeIrq) |-> $past(stb.commit));

  // R8: a clear without a commit drops the interrupt
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrIrq && !stb.commit) |=> !changeIrq);
endmodule

// File: rtl/casChangeDetect.sv
module casChangeDetect
  import casPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ts16Valid,
  input  logic [BYTE_W-1:0] ts16Byte,
  input  logic [IDX_W-1:0]  frameNum,
  input  logic              ts0Sync,
  input  logic              mfSync,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [BYTE_W-1:0] rdData,
  input  logic              clrIrq,
  output logic              changeIrq
);
  casStrobe_t stb;

  casCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ts16Valid(ts16Valid), .frameNum(frameNum),
    .ts0Sync(ts0Sync), .mfSync(mfSync), .stb(stb)
  );

  casData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .ts16Byte(ts16Byte), .rdAddr(rdAddr),
    .clrIrq(clrIrq), .rdData(rdData), .changeIrq(changeIrq)
  );
endmodule

// File: tb/sim_casChangeDetect.sv
module sim_casChangeDetect;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ts16Valid = 1'b0;
  logic [7:0] ts16Byte = '0;
  logic [3:0] frameNum = '0;
  logic       ts0Sync = 1'b1;
  logic       mfSync = 1'b1;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       clrIrq = 1'b0;
  logic       changeIrq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  casChangeDetect u0 (
    .clk(clk), .rstN(rstN), .ts16Valid(ts16Valid), .ts16Byte(ts16Byte),
    .frameNum(frameNum), .ts0Sync(ts0Sync), .mfSync(mfSync), .rdAddr(rdAddr),
    .rdData(rdData), .clrIrq(clrIrq), .changeIrq(changeIrq)
  );

  function automatic logic [7:0] pat(input int sel, input int i);
    case (sel)
      0:       return 8'hFF;
      1:       return 8'h10 + 8'(i);
      2:       return 8'h41 + 8'(i * 3);
      3:       return ~(8'h10 + 8'(i));
      default: return ~(8'h10 + 8'(i)) ^ 8'h5A;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input int f, input logic [7:0] b);
    @(negedge clk);
    ts16Valid = 1'b1; frameNum = 4'(f); ts16Byte = b;
    @(negedge clk);
    ts16Valid = 1'b0;
  endtask

  task automatic sendMf(input int sel);
    for (int i = 0; i < 16; i++) sendByte(i, pat(sel, i));
  endtask

  task automatic checkBank(input int sel, input string tag);
    for (int i = 0; i < 16; i++) begin
      rdAddr = 4'(i);
      #1;
      chk(rdData, pat(sel, i), tag);
    end
  endtask

  task automatic clearIrq();
    @(negedge clk); clrIrq = 1'b1;
    @(negedge clk); clrIrq = 1'b0;
    chk({7'd0, changeIrq}, 8'd0, "R8 clear");
  endtask

  task automatic tReset();
    chk({7'd0, changeIrq}, 8'd0, "R1 irq after reset");
    checkBank(0, "R1 bank after reset");
  endtask

  task automatic tFirst();
    sendMf(1);
    chk({7'd0, changeIrq}, 8'd0, "R4 not on capture edge");
    @(negedge clk);
    chk({7'd0, changeIrq}, 8'd1, "R4 irq after commit");
    checkBank(1, "R2 frame to register");
    repeat (3) @(negedge clk);
    chk({7'd0, changeIrq}, 8'd1, "R8 sticky");
    clearIrq();
  endtask

  task automatic tSame();
    sendMf(1);
    repeat (2) @(negedge clk);
    chk({7'd0, changeIrq}, 8'd0, "R5 identical no irq");
    checkBank(1, "R5 bank unchanged");
  endtask

  task automatic tMidRead();
    for (int i = 0; i < 8; i++) sendByte(i, pat(2, i));
    rdAddr = 4'd0; #1;
    chk(rdData, pat(1, 0), "R3 mid read reg0");
    rdAddr = 4'd5; #1;
    chk(rdData, pat(1, 5), "R3 mid read reg5");
    for (int i = 8; i < 16; i++) sendByte(i, pat(2, i));
    @(negedge clk);
    chk({7'd0, changeIrq}, 8'd1, "R4 change irq");
    checkBank(2, "R2 new bank");
    clearIrq();
  endtask

  task automatic tSyncLoss(input bit useTs0);
    for (int i = 0; i < 5; i++) sendByte(i, pat(3, i));
    @(negedge clk);
    if (useTs0) ts0Sync = 1'b0; else mfSync = 1'b0;
    @(negedge clk);
    ts0Sync = 1'b1; mfSync = 1'b1;
    for (int i = 5; i < 16; i++) sendByte(i, pat(3, i));
    repeat (2) @(negedge clk);
    chk({7'd0, changeIrq}, 8'd0, useTs0 ? "R6 ts0 loss irq" : "R6 mf loss irq");
    checkBank(2, useTs0 ? "R6 ts0 loss bank" : "R6 mf loss bank");
  endtask

  task automatic tSkip();
    for (int i = 0; i < 16; i++) if (i != 7) sendByte(i, pat(3, i));
    repeat (2) @(negedge clk);
    chk({7'd0, changeIrq}, 8'd0, "R7 skipped frame irq");
    checkBank(2, "R7 skipped frame bank");
    for (int i = 3; i < 16; i++) sendByte(i, pat(3, i));
    repeat (2) @(negedge clk);
    chk({7'd0, changeIrq}, 8'd0, "R7 no frame0 irq");
    checkBank(2, "R7 no frame0 bank");
  endtask

  task automatic tSetWins();
    sendMf(3);
    @(negedge clk);
    chk({7'd0, changeIrq}, 8'd1, "R8 change set");
    clearIrq();
    sendMf(4);
    clrIrq = 1'b1;
    @(negedge clk);
    clrIrq = 1'b0;
    chk({7'd0, changeIrq}, 8'd1, "R8 set wins over clear");
    checkBank(4, "R2 bank D");
    clearIrq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFirst();
    tSame();
    tMidRead();
    tSyncLoss(1'b1);
    tSyncLoss(1'b0);
    tSkip();
    tSetWins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule